// File: doc/BRIEF.md
# Audio Control Register Write Receiver

This block is the control-register front end of an audio processor. It sits on a two-wire serial bus as a write-only target. It oversamples the bus clock and data lines with a faster system clock and detects START and STOP conditions. It then shifts in bytes and pulls the data line low in the ninth clock of every accepted byte to acknowledge it.

A transfer begins with a fixed device-address byte. The next byte is a register subaddress, and every byte after that is data. Each data byte goes to the register the subaddress selects, and the selection then steps to the next register. The eight registers drive decoded parallel fields for the signal path: volume, loudness-off, zero-cross mode, four fader attenuations, bass, treble, source select and general mute. A one-clock strobe marks each completed write to the switch register, so that a mute timer downstream can restart.

The receiver is a state machine with seven states:
- IDLE: the bus is free.
- ADDR: receiving the address byte.
- SUB: receiving the subaddress byte.
- DATA: receiving data bytes.
- ACKW: a byte has been accepted, waiting for SCL to fall.
- ACKD: driving the acknowledge.
- SKIP: the address did not match, ignore the bus.

Its transitions are:
- Any state goes to IDLE on STOP, and to ADDR on START or repeated START.
- ADDR goes to ACKW on a matching address, returning to SUB afterwards, and to SKIP on any other address.
- SUB goes to ACKW after 8 bits, returning to DATA.
- DATA goes to ACKW after 8 bits, returning to DATA.
- ACKW goes to ACKD on an SCL fall.
- ACKD goes to its return state on the next SCL fall.

Top module: `fader_reg_slave`

## Requirements
- R1: After reset `gen_mute` is 1, every other field and `sw_stb` are 0, and `sda_oe` is 0 (the data line is released).
- R2: An address byte of 0x80 (bits sent MSB first) is acknowledged: `sda_oe` is 1 while SCL is high in the ninth clock.
- R3: Any other address byte is not acknowledged. Every following byte of that transfer is also not acknowledged, and no register changes.
- R4: The byte after an accepted address is acknowledged and taken as the subaddress. Only its bits 2..0 count, selecting 0 volume, 1 fader front right, 2 fader front left, 3 fader rear right, 4 fader rear left, 5 bass, 6 treble, 7 switch. Bits 7..3 are ignored.
- R5: Every data byte is acknowledged and written to the selected register, and the selection then increments by one. A register changes only when one of its data bytes completes.
- R6: The selection wraps from 7 to 0.
- R7: In the volume register, bit 7 sets `zc_mode`, bit 6 sets `loud_off` and bits 5..0 set `vol_code`.
- R8: Each fader register takes bits 5..0 into its attenuation field. The bass and treble registers take bits 4..0. All other bits are ignored.
- R9: In the switch register, bit 7 sets `gen_mute` and bits 2..0 set `src_sel`. Bits 6..3 are ignored.
- R10: `sw_stb` is high for exactly one clock per completed switch-register write and never at any other time.
- R11: A STOP or a repeated START ends the sequence. A byte cut short writes nothing, and after a repeated START the address and then a new subaddress are expected again.
- R12: `sda_oe` changes only while SCL is low, never while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (sensed) |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| vol_code | output | 6 | Volume code |
| loud_off | output | 1 | Loudness disabled |
| zc_mode | output | 1 | Zero-cross mute mode |
| fad_fr | output | 6 | Front-right attenuation |
| fad_fl | output | 6 | Front-left attenuation |
| fad_rr | output | 6 | Rear-right attenuation |
| fad_rl | output | 6 | Rear-left attenuation |
| bass_code | output | 5 | Bass setting |
| treb_code | output | 5 | Treble setting |
| src_sel | output | 3 | Source select |
| gen_mute | output | 1 | General mute |
| sw_stb | output | 1 | One-clock pulse per switch-register write |

## Verification
The assertions check on every cycle that the acknowledge drive never moves while SCL is high, that STOP always returns the receiver to IDLE, and that the register selection wraps from 7 to 0. They also check that no field changes without a write and that the switch strobe never lasts two clocks. Address rejection, the field layouts, auto-increment across a full sweep, the effect of repeated START and cut-short bytes, and the exact strobe count can only be shown by the bench's transfers. The bench compares all fields against its behavioural model on every clock.

// File: rtl/frs_pkg.sv
package frs_pkg;
    localparam int VOL_W  = 6;
    localparam int FAD_W  = 6;
    localparam int TONE_W = 5;
    localparam int SRC_W  = 3;
    localparam int IDX_W  = 3;
    localparam int NREG   = 1 << IDX_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_ACKW,
        ST_ACKD,
        ST_SKIP
    } rx_state_t;
endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_chain, sda_chain;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_q     <= scl_chain[STAGES-1];
            sda_q     <= sda_chain[STAGES-1];
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/frs_fsm.sv
module frs_fsm
    import frs_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    rx_state_t        state, state_nx, ret_st, ret_nx;
    logic [2:0]       bit_cnt;
    logic [6:0]       shreg;
    logic [IDX_W-1:0] ptr;
    logic             rx_phase, byte_done;
    logic [7:0]       full_byte;

    assign rx_phase  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign byte_done = rx_phase && scl_rise && (bit_cnt == 3'd7);
    assign full_byte = {shreg, sda_s};

    always_comb begin
        state_nx = state;
        ret_nx   = ret_st;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_ADDR: if (byte_done) begin
                    if (full_byte == DEV_ADDR) begin
                        state_nx = ST_ACKW;
                        ret_nx   = ST_SUB;
                    end else begin
                        state_nx = ST_SKIP;
                    end
                end
                ST_SUB: if (byte_done) begin
                    state_nx = ST_ACKW;
                    ret_nx   = ST_DATA;
                end
                ST_DATA: if (byte_done) begin
                    state_nx = ST_ACKW;
                    ret_nx   = ST_DATA;
                end
                ST_ACKW: if (scl_fall) state_nx = ST_ACKD;
                ST_ACKD: if (scl_fall) state_nx = ret_st;
                ST_SKIP: state_nx = ST_SKIP;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ret_st  <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
        end else begin
            state  <= state_nx;
            ret_st <= ret_nx;
            if (start_det || !rx_phase)
                bit_cnt <= '0;
            else if (scl_rise)
                bit_cnt <= bit_cnt + 3'd1;
            if (rx_phase && scl_rise)
                shreg <= full_byte[6:0];
            if (byte_done && state == ST_SUB)
                ptr <= full_byte[IDX_W-1:0];
            else if (byte_done && state == ST_DATA)
                ptr <= ptr + 1'b1;
        end
    end

    always_comb begin
        sda_oe  = (state == ST_ACKD);
        wr_en   = byte_done && (state == ST_DATA);
        wr_idx  = ptr;
        wr_data = full_byte;
    end

    assert_ack_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));
    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));
    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == '1) |=> (ptr == '0));
endmodule

// File: rtl/frs_regfile.sv
module frs_regfile
    import frs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    output logic [VOL_W-1:0]  vol_code,
    output logic              loud_off,
    output logic              zc_mode,
    output logic [FAD_W-1:0]  fad_fr,
    output logic [FAD_W-1:0]  fad_fl,
    output logic [FAD_W-1:0]  fad_rr,
    output logic [FAD_W-1:0]  fad_rl,
    output logic [TONE_W-1:0] bass_code,
    output logic [TONE_W-1:0] treb_code,
    output logic [SRC_W-1:0]  src_sel,
    output logic              gen_mute,
    output logic              sw_stb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vol_code  <= '0;
            loud_off  <= 1'b0;
            zc_mode   <= 1'b0;
            fad_fr    <= '0;
            fad_fl    <= '0;
            fad_rr    <= '0;
            fad_rl    <= '0;
            bass_code <= '0;
            treb_code <= '0;
            src_sel   <= '0;
            gen_mute  <= 1'b1;
            sw_stb    <= 1'b0;
        end else begin
            sw_stb <= wr_en && (wr_idx == IDX_W'(7));
            if (wr_en) begin
                case (wr_idx)
                    IDX_W'(0): begin
                        zc_mode  <= wr_data[7];
                        loud_off <= wr_data[6];
                        vol_code <= wr_data[VOL_W-1:0];
                    end
                    IDX_W'(1): fad_fr    <= wr_data[FAD_W-1:0];
                    IDX_W'(2): fad_fl    <= wr_data[FAD_W-1:0];
                    IDX_W'(3): fad_rr    <= wr_data[FAD_W-1:0];
                    IDX_W'(4): fad_rl    <= wr_data[FAD_W-1:0];
                    IDX_W'(5): bass_code <= wr_data[TONE_W-1:0];
                    IDX_W'(6): treb_code <= wr_data[TONE_W-1:0];
                    default: begin
                        gen_mute <= wr_data[7];
                        src_sel  <= wr_data[SRC_W-1:0];
                    end
                endcase
            end
        end
    end

    assert_hold_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({vol_code, loud_off, zc_mode, fad_fr, fad_fl, fad_rr, fad_rl,
                            bass_code, treb_code, src_sel, gen_mute}));
    assert_stb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stb |=> !sw_stb);
endmodule

// File: rtl/fader_reg_slave.sv
module fader_reg_slave
    import frs_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'h80,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [VOL_W-1:0]  vol_code,
    output logic              loud_off,
    output logic              zc_mode,
    output logic [FAD_W-1:0]  fad_fr,
    output logic [FAD_W-1:0]  fad_fl,
    output logic [FAD_W-1:0]  fad_rr,
    output logic [FAD_W-1:0]  fad_rl,
    output logic [TONE_W-1:0] bass_code,
    output logic [TONE_W-1:0] treb_code,
    output logic [SRC_W-1:0]  src_sel,
    output logic              gen_mute,
    output logic              sw_stb
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0] wr_data;

    frs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    frs_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    frs_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .vol_code(vol_code), .loud_off(loud_off), .zc_mode(zc_mode),
        .fad_fr(fad_fr), .fad_fl(fad_fl), .fad_rr(fad_rr), .fad_rl(fad_rl),
        .bass_code(bass_code), .treb_code(treb_code), .src_sel(src_sel),
        .gen_mute(gen_mute), .sw_stb(sw_stb)
    );
endmodule

// File: tb/fader_reg_slave_tb.sv
module fader_reg_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, loud_off, zc_mode, gen_mute, sw_stb;
    logic [5:0] vol_code, fad_fr, fad_fl, fad_rr, fad_rl;
    logic [4:0] bass_code, treb_code;
    logic [2:0] src_sel;
    logic sda_line;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    fader_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .vol_code(vol_code), .loud_off(loud_off), .zc_mode(zc_mode),
        .fad_fr(fad_fr), .fad_fl(fad_fl), .fad_rr(fad_rr), .fad_rl(fad_rl),
        .bass_code(bass_code), .treb_code(treb_code), .src_sel(src_sel),
        .gen_mute(gen_mute), .sw_stb(sw_stb)
    );

    int checks = 0, errors = 0;
    bit cmp_on = 0, hold = 0, done = 0, stb_prev = 0;
    int stb_cnt = 0, exp_stb = 0;
    int mptr = 0;
    // behavioural reference state
    bit m_zc = 0, m_lo = 0, m_gm = 1;
    bit [5:0] m_vol = 0;
    bit [5:0] m_fad [4] = '{default: 0};
    bit [4:0] m_bass = 0, m_treb = 0;
    bit [2:0] m_src = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [45:0] dut_vec();
        return {zc_mode, loud_off, vol_code, fad_fr, fad_fl, fad_rr, fad_rl,
                bass_code, treb_code, src_sel, gen_mute};
    endfunction

    function automatic logic [45:0] mdl_vec();
        return {m_zc, m_lo, m_vol, m_fad[0], m_fad[1], m_fad[2], m_fad[3],
                m_bass, m_treb, m_src, m_gm};
    endfunction

    // register index map: 0 vol, 1..4 faders FR FL RR RL, 5 bass, 6 treble, 7 switch
    task automatic model_write(input bit [7:0] b);
        case (mptr)
            0: begin m_zc = b[7]; m_lo = b[6]; m_vol = b[5:0]; end
            1, 2, 3, 4: m_fad[mptr-1] = b[5:0];
            5: m_bass = b[4:0];
            6: m_treb = b[4:0];
            default: begin m_gm = b[7]; m_src = b[2:0]; exp_stb++; end
        endcase
        mptr = (mptr + 1) % 8;
    endtask

    // every-clock comparison against the reference model (R5 R7 R8 R9)
    always @(negedge clk) begin
        if (cmp_on && !hold)
            chk(dut_vec() === mdl_vec(), "R5_R7_R8_R9 fields", 64'(dut_vec()), 64'(mdl_vec()));
        if (cmp_on) begin
            if (sw_stb) stb_cnt++;
            if (sw_stb && stb_prev) chk(0, "R10 strobe width", 2, 1);
        end
        stb_prev = sw_stb;
    end

    task automatic bus_start();
        sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(2 * H);
    endtask

    task automatic send_byte(input bit [7:0] b, input bit exp_ack, input bit mwrite, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H);
            if (i == 0) hold = 1;
            scl_m = 1'b1; wt(H); scl_m = 1'b0;
        end
        wt(5);
        if (mwrite) model_write(b);
        hold = 0;
        sda_m = 1'b1; wt(H - 5);
        scl_m = 1'b1; wt(H / 2);
        chk(sda_oe === exp_ack, req, 64'(sda_oe), 64'(exp_ack));
        wt(H - H / 2); scl_m = 1'b0; wt(1);
    endtask

    task automatic send_bits(input bit [3:0] b);
        for (int i = 3; i >= 0; i--) begin
            sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
        end
        wt(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wt(4);
        // R1 reset state
        chk(gen_mute === 1'b1, "R1 gen_mute", 64'(gen_mute), 1);
        chk(dut_vec() === 46'h1, "R1 fields", 64'(dut_vec()), 1);
        chk(sda_oe === 1'b0 && sw_stb === 1'b0, "R1 oe/stb", {sda_oe, sw_stb}, 0);
        rst_n = 1'b1; wt(4);
        chk(dut_vec() === 46'h1, "R1 after release", 64'(dut_vec()), 1);
        cmp_on = 1;

        // full sweep from register 0 through switch (R2 R4 R5 R7 R8 R9)
        bus_start();
        send_byte(8'h80, 1, 0, "R2 address ack");
        send_byte(8'h00, 1, 0, "R4 sub ack"); mptr = 0;
        send_byte(8'hC5, 1, 1, "R5 data ack vol");
        send_byte(8'h3A, 1, 1, "R5 data ack ffr");
        send_byte(8'hD1, 1, 1, "R8 data ack ffl");
        send_byte(8'h7F, 1, 1, "R5 data ack frr");
        send_byte(8'h22, 1, 1, "R5 data ack frl");
        send_byte(8'hEC, 1, 1, "R8 data ack bass");
        send_byte(8'h13, 1, 1, "R5 data ack treble");
        send_byte(8'h7D, 1, 1, "R9 data ack switch");
        bus_stop();
        chk(gen_mute === 1'b0 && src_sel === 3'd5, "R9 switch decode", {gen_mute, src_sel}, 5);
        chk(stb_cnt == exp_stb, "R10 strobe count", stb_cnt, exp_stb);

        // high subaddress bits ignored, wrap 7 -> 0 (R4 R6)
        bus_start();
        send_byte(8'h80, 1, 0, "R2 address ack");
        send_byte(8'hFE, 1, 0, "R4 sub ack"); mptr = 6;
        send_byte(8'hFF, 1, 1, "R8 treble masked");
        send_byte(8'h83, 1, 1, "R9 switch mute on");
        send_byte(8'h3F, 1, 1, "R6 wrapped to volume");
        bus_stop();
        chk(vol_code === 6'h3F && zc_mode === 1'b0, "R6 wrap target", {zc_mode, vol_code}, 8'h3F);
        chk(stb_cnt == exp_stb, "R10 strobe count", stb_cnt, exp_stb);

        // wrong address: nothing acked, nothing written (R3)
        bus_start();
        send_byte(8'h82, 0, 0, "R3 address nack");
        send_byte(8'h01, 0, 0, "R3 sub ignored");
        send_byte(8'h15, 0, 0, "R3 data ignored");
        bus_stop();
        chk(fad_fr === m_fad[0], "R3 register held", 64'(fad_fr), 64'(m_fad[0]));

        // repeated START restarts with address then subaddress (R11)
        bus_start();
        send_byte(8'h80, 1, 0, "R2 address ack");
        send_byte(8'h03, 1, 0, "R4 sub ack"); mptr = 3;
        send_byte(8'h2A, 1, 1, "R5 rear right");
        bus_rstart();
        send_byte(8'h80, 1, 0, "R11 address after restart");
        send_byte(8'h01, 1, 0, "R11 sub after restart"); mptr = 1;
        send_byte(8'h11, 1, 1, "R11 data after restart");
        bus_stop();
        chk(fad_fr === 6'h11 && fad_rr === 6'h2A, "R11 restart targets", {fad_fr, fad_rr}, {6'h11, 6'h2A});

        // byte cut short by STOP writes nothing (R11)
        bus_start();
        send_byte(8'h80, 1, 0, "R2 address ack");
        send_byte(8'h05, 1, 0, "R4 sub ack"); mptr = 5;
        send_bits(4'hF);
        bus_stop();
        chk(bass_code === m_bass, "R11 partial byte dropped", 64'(bass_code), 64'(m_bass));
        bus_start();
        send_byte(8'h80, 1, 0, "R2 address ack");
        send_byte(8'h05, 1, 0, "R4 sub ack"); mptr = 5;
        send_byte(8'hEA, 1, 1, "R8 bass masked");
        bus_stop();
        chk(bass_code === 5'h0A, "R8 bass value", 64'(bass_code), 5'h0A);
        chk(stb_cnt == exp_stb, "R10 strobe count", stb_cnt, exp_stb);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule